// File: doc/BRIEF.md
# Command-Queue SPI Master

This block is a single-lane SPI master that works through a queue of up to sixteen transfer entries without help from a processor. Each entry has a command byte, two transmit bytes and two receive bytes. Software loads the command, transmit and divider settings over a small byte-wide register bus. It then picks the first and last entries to run and writes the run register. The engine shifts each entry out MSB-first on the serial clock and data-out line and captures the data-in line into receive storage. When the last entry is done it raises a completion flag.

Each entry is either 8 or 16 bits long. It chooses one of two peripheral selects, and it can keep its select asserted into the next entry so that several entries form one frame. The serial clock runs at the system clock divided by twice a divider value, and the divider is clamped to the range 8 to 255. All four clock polarity and phase modes are supported.

Top module: `spi_cmdq_master`

## Requirements
- R1: After reset both selects are high (`cs_n_o` = 2'b11), the serial clock is low, `done_o` is 0, the receive bytes read 0 and the divider register (address 0x00) reads 8.
- R2: A divider write (0x00) is stored clamped to the range 8..255, and each half-period of the serial clock lasts exactly that many system clocks.
- R3: Writing 0x40 to the run register (0x04) starts the queue at the start pointer (0x02). The engine then runs entries in ascending order, wrapping from 15 to 0, up to and including the end pointer (0x03), and sets `done_o` (status 0x05 bit 0) after the last entry.
- R4: A narrow entry i shifts transmit byte 0x40+2i MSB-first and stores 8 received bits, first bit in the MSB, at receive address 0x80+2i.
- R5: Command bit 6 (commands live at 0xC0+i) makes entry i 16 bits wide. Byte 0x40+2i is shifted first, then 0x41+2i, and the received bytes go to 0x80+2i (first) and 0x81+2i (second).
- R6: Mode register (0x01) bit 5 forces every entry to 8 bits whatever its command bit 6 says. The second receive byte of such an entry is left unchanged.
- R7: Mode bit 1 is the clock idle level and bit 0 selects the phase. With phase 0 both sides sample on the leading edge, and with phase 1 they sample on the trailing edge.
- R8: Command bits 1:0 choose the select: code 2 drives `cs_n_o[0]` low, code 3 drives `cs_n_o[1]` low, and codes 0 and 1 assert no select although the clock still runs.
- R9: Command bit 7 keeps the select low into the next entry. When it is clear on a non-final entry, the select goes high between entries.
- R10: On the final entry the select stays low exactly when run-register bit 7 was set by the starting write. Otherwise it is released.
- R11: Writing a value with bit 0 clear to the status register (0x05) clears `done_o`.
- R12: Writing a value with bit 6 clear to the run register aborts at once: selects go high, the clock returns to idle and `done_o` is not set.
- R13: The first clock edge of an entry follows the select's falling edge by one half-period. The select rises one half-period after the last edge of an entry that releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 2 | Active-low peripheral selects |
| done_o | output | 1 | Queue-complete flag |

## Verification
The hardest case to reach from the ports is a frame held across entries and across a queue boundary. A frame of that kind exposes the continuation logic and the wrap of the entry pointer together. The stimulus builds a three-entry continued frame, a queue that runs from entry 15 through 0 to 1, and a run whose final select is kept low on purpose. A bench peripheral model shifts one continuous bit stream for as long as its select stays low, so a wrongly released or wrongly held select shows up as shifted receive bytes. A long wide queue is aborted mid-entry to catch the engine in its busiest state.

// File: rtl/spi_cmdq_pkg.sv
package spi_cmdq_pkg;

  localparam int unsigned DIV_LO   = 8;
  localparam int unsigned DIV_HI   = 255;
  localparam int unsigned CS_BASE  = 2;

  // register byte addresses in the control region
  localparam logic [5:0] A_DIV   = 6'h00;
  localparam logic [5:0] A_MODE  = 6'h01;
  localparam logic [5:0] A_QBEG  = 6'h02;
  localparam logic [5:0] A_QEND  = 6'h03;
  localparam logic [5:0] A_RUN   = 6'h04;
  localparam logic [5:0] A_STAT  = 6'h05;

  // address regions selected by bus_addr[7:6]
  localparam logic [1:0] RG_CTL = 2'd0;
  localparam logic [1:0] RG_TX  = 2'd1;
  localparam logic [1:0] RG_RX  = 2'd2;
  localparam logic [1:0] RG_CMD = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_SHIFT, ST_HOLD, ST_GAP
  } eng_st_t;

  function automatic logic [7:0] clamp_div(input logic [7:0] v);
    if (v < 8'(DIV_LO)) return 8'(DIV_LO);
    if (v > 8'(DIV_HI)) return 8'(DIV_HI);
    return v;
  endfunction

  // index of the final clock edge of an entry: two edges per bit
  function automatic logic [4:0] last_edge_idx(input logic wide);
    return wide ? 5'd31 : 5'd15;
  endfunction

endpackage

// File: rtl/spi_cmdq_tick.sv
module spi_cmdq_tick #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [DW-1:0] div_i,
  output logic          tick_o
);
  logic [DW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i - DW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!en_i)    cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else               cnt_q <= cnt_q + DW'(1);
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/spi_cmdq_regs.sv
module spi_cmdq_regs
  import spi_cmdq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int BW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [7:0]    bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic [7:0]    div_o,
  output logic          cpol_o,
  output logic          cpha_o,
  output logic          force8_o,
  output logic [PW-1:0] qbeg_o,
  output logic [PW-1:0] qend_o,
  output logic          hold_last_o,
  output logic          go_o,
  output logic          abort_o,
  output logic          done_o,
  input  logic          fin_i,
  input  logic [PW-1:0] rd_idx_i,
  output logic [7:0]    cmd_o,
  output logic [15:0]   tx_o,
  input  logic          rx_we_i,
  input  logic [PW-1:0] rx_idx_i,
  input  logic          rx_wide_i,
  input  logic [15:0]   rx_data_i
);
  logic [7:0] div_q, mode_q, run_q;
  logic [PW-1:0] qbeg_q, qend_q;
  logic done_q;
  logic [7:0] tx_m  [2*DEPTH];
  logic [7:0] rx_m  [2*DEPTH];
  logic [7:0] cmd_m [DEPTH];

  logic [1:0] rg;
  logic [5:0] idx;
  logic in_bytes, in_cmds;
  assign rg       = bus_addr[7:6];
  assign idx      = bus_addr[5:0];
  assign in_bytes = idx < 6'(2*DEPTH);
  assign in_cmds  = idx < 6'(DEPTH);

  logic wr_ctl;
  assign wr_ctl  = bus_wr && rg == RG_CTL;
  assign go_o    = wr_ctl && idx == A_RUN && bus_wdata[6];
  assign abort_o = wr_ctl && idx == A_RUN && !bus_wdata[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= 8'(DIV_LO);
      mode_q <= '0;
      run_q  <= '0;
      qbeg_q <= '0;
      qend_q <= '0;
      done_q <= 1'b0;
      for (int i = 0; i < 2*DEPTH; i++) begin
        tx_m[i] <= '0;
        rx_m[i] <= '0;
      end
      for (int i = 0; i < DEPTH; i++) cmd_m[i] <= '0;
    end else begin
      if (wr_ctl) begin
        case (idx)
          A_DIV:  div_q  <= clamp_div(bus_wdata);
          A_MODE: mode_q <= bus_wdata;
          A_QBEG: qbeg_q <= bus_wdata[PW-1:0];
          A_QEND: qend_q <= bus_wdata[PW-1:0];
          A_RUN:  run_q  <= bus_wdata;
          default: ;
        endcase
      end
      if (bus_wr && rg == RG_TX && in_bytes) tx_m[idx[BW-1:0]] <= bus_wdata;
      if (bus_wr && rg == RG_CMD && in_cmds) cmd_m[idx[PW-1:0]] <= bus_wdata;
      if (rx_we_i) begin
        rx_m[{rx_idx_i, 1'b0}] <= rx_data_i[15:8];
        if (rx_wide_i) rx_m[{rx_idx_i, 1'b1}] <= rx_data_i[7:0];
      end
      if (fin_i) done_q <= 1'b1;
      else if (wr_ctl && idx == A_STAT && !bus_wdata[0]) done_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (rg)
      RG_CTL: case (idx)
        A_DIV:  bus_rdata = div_q;
        A_MODE: bus_rdata = mode_q;
        A_QBEG: bus_rdata = 8'(qbeg_q);
        A_QEND: bus_rdata = 8'(qend_q);
        A_RUN:  bus_rdata = run_q;
        A_STAT: bus_rdata = {7'd0, done_q};
        default: bus_rdata = '0;
      endcase
      RG_TX:  if (in_bytes) bus_rdata = tx_m[idx[BW-1:0]];
      RG_RX:  if (in_bytes) bus_rdata = rx_m[idx[BW-1:0]];
      default: if (in_cmds) bus_rdata = cmd_m[idx[PW-1:0]];
    endcase
  end

  assign div_o       = div_q;
  assign cpol_o      = mode_q[1];
  assign cpha_o      = mode_q[0];
  assign force8_o    = mode_q[5];
  assign qbeg_o      = qbeg_q;
  assign qend_o      = qend_q;
  assign hold_last_o = run_q[7];
  assign done_o      = done_q;
  assign cmd_o       = cmd_m[rd_idx_i];
  assign tx_o        = {tx_m[{rd_idx_i, 1'b0}], tx_m[{rd_idx_i, 1'b1}]};

  // R3
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(fin_i));

endmodule

// File: rtl/spi_cmdq_engine.sv
module spi_cmdq_engine
  import spi_cmdq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NCS   = 2,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go_i,
  input  logic           abort_i,
  input  logic [PW-1:0]  qbeg_i,
  input  logic [PW-1:0]  qend_i,
  input  logic           hold_last_i,
  input  logic           cpol_i,
  input  logic           cpha_i,
  input  logic           force8_i,
  input  logic           tick_i,
  input  logic [7:0]     cmd_i,
  input  logic [15:0]    tx_i,
  input  logic           miso_i,
  output logic [PW-1:0]  ptr_o,
  output logic           tick_en_o,
  output logic           sck_o,
  output logic           mosi_o,
  output logic [NCS-1:0] cs_n_o,
  output logic           rx_we_o,
  output logic           rx_wide_o,
  output logic [15:0]    rx_data_o,
  output logic           fin_o
);
  eng_st_t st_q;
  logic [PW-1:0] ptr_q;
  logic [4:0]  ecnt_q;
  logic [15:0] tx_sr, rx_sr;
  logic wide_q, cont_q, sck_r, cs_act;
  logic [1:0] dev_q;

  logic unused_cmd_bits;
  assign unused_cmd_bits = ^cmd_i[5:2];

  logic seg_end, is_last, keep_cs, samp, at_last, ld_wide;
  assign seg_end = (st_q == ST_HOLD) && tick_i;
  assign is_last = ptr_q == qend_i;
  assign keep_cs = is_last ? hold_last_i : cont_q;
  assign samp    = ecnt_q[0] == cpha_i;
  assign at_last = ecnt_q == last_edge_idx(wide_q);
  assign ld_wide = cmd_i[6] && !force8_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      ecnt_q <= '0;
      tx_sr  <= '0;
      rx_sr  <= '0;
      wide_q <= 1'b0;
      cont_q <= 1'b0;
      sck_r  <= 1'b0;
      cs_act <= 1'b0;
      dev_q  <= '0;
    end else if (abort_i) begin
      st_q   <= ST_IDLE;
      cs_act <= 1'b0;
      sck_r  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (go_i) begin
          ptr_q <= qbeg_i;
          st_q  <= ST_LOAD;
        end
        ST_LOAD: begin
          wide_q <= ld_wide;
          tx_sr  <= ld_wide ? tx_i : {tx_i[15:8], 8'h00};
          cont_q <= cmd_i[7];
          dev_q  <= cmd_i[1:0];
          cs_act <= 1'b1;
          ecnt_q <= '0;
          rx_sr  <= '0;
          st_q   <= ST_SHIFT;
        end
        ST_SHIFT: if (tick_i) begin
          sck_r <= ~sck_r;
          if (samp)               rx_sr <= {rx_sr[14:0], miso_i};
          else if (ecnt_q != '0)  tx_sr <= {tx_sr[14:0], 1'b0};
          if (at_last) st_q <= ST_HOLD;
          else         ecnt_q <= ecnt_q + 5'd1;
        end
        ST_HOLD: if (tick_i) begin
          cs_act <= keep_cs;
          if (is_last) st_q <= ST_IDLE;
          else begin
            ptr_q <= ptr_q + 1'b1;
            st_q  <= keep_cs ? ST_LOAD : ST_GAP;
          end
        end
        ST_GAP: if (tick_i) st_q <= ST_LOAD;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  generate
    for (genvar d = 0; d < NCS; d++) begin : g_cs
      assign cs_n_o[d] = !(cs_act && dev_q == 2'(CS_BASE + d));
    end
  endgenerate

  assign ptr_o     = ptr_q;
  assign tick_en_o = st_q == ST_SHIFT || st_q == ST_HOLD || st_q == ST_GAP;
  assign sck_o     = sck_r ^ cpol_i;
  assign mosi_o    = tx_sr[15];
  assign rx_we_o   = seg_end;
  assign rx_wide_o = wide_q;
  assign rx_data_o = wide_q ? rx_sr : {rx_sr[7:0], 8'h00};
  assign fin_o     = seg_end && is_last;

  // R2
  sck_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !abort_i) |=> $stable(sck_r));

  // R12
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> ((&cs_n_o) && !sck_r));

  // R9
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&cs_n_o) |-> $past(seg_end || abort_i || st_q == ST_LOAD));

endmodule

// File: rtl/spi_cmdq_master.sv
module spi_cmdq_master
  import spi_cmdq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NCS   = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [7:0]     bus_addr,
  input  logic [7:0]     bus_wdata,
  output logic [7:0]     bus_rdata,
  output logic           sck_o,
  output logic           mosi_o,
  input  logic           miso_i,
  output logic [NCS-1:0] cs_n_o,
  output logic           done_o
);
  localparam int PW = $clog2(DEPTH);

  logic [7:0] div;
  logic cpol, cpha, force8, hold_last, go, abort, fin, tick, tick_en;
  logic rx_we, rx_wide;
  logic [PW-1:0] qbeg, qend, ptr;
  logic [7:0] cmd;
  logic [15:0] tx, rx_data;

  spi_cmdq_regs #(.DEPTH(DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .div_o(div), .cpol_o(cpol), .cpha_o(cpha), .force8_o(force8),
    .qbeg_o(qbeg), .qend_o(qend), .hold_last_o(hold_last),
    .go_o(go), .abort_o(abort), .done_o(done_o), .fin_i(fin),
    .rd_idx_i(ptr), .cmd_o(cmd), .tx_o(tx),
    .rx_we_i(rx_we), .rx_idx_i(ptr), .rx_wide_i(rx_wide), .rx_data_i(rx_data)
  );

  spi_cmdq_tick #(.DW(8)) u_tick (
    .clk(clk), .rst_n(rst_n), .en_i(tick_en), .div_i(div), .tick_o(tick)
  );

  spi_cmdq_engine #(.DEPTH(DEPTH), .NCS(NCS)) u_eng (
    .clk(clk), .rst_n(rst_n), .go_i(go), .abort_i(abort),
    .qbeg_i(qbeg), .qend_i(qend), .hold_last_i(hold_last),
    .cpol_i(cpol), .cpha_i(cpha), .force8_i(force8), .tick_i(tick),
    .cmd_i(cmd), .tx_i(tx), .miso_i(miso_i),
    .ptr_o(ptr), .tick_en_o(tick_en), .sck_o(sck_o), .mosi_o(mosi_o),
    .cs_n_o(cs_n_o), .rx_we_o(rx_we), .rx_wide_o(rx_wide),
    .rx_data_o(rx_data), .fin_o(fin)
  );

endmodule

// File: tb/spi_cmdq_master_tb.sv
`timescale 1ns/1ps
module spi_cmdq_master_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic sck_o, mosi_o, miso_i, done_o;
  logic [1:0] cs_n_o;

  spi_cmdq_master u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_o(sck_o),
    .mosi_o(mosi_o), .miso_i(miso_i), .cs_n_o(cs_n_o), .done_o(done_o)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  // bench view of the serial side
  bit cpol_b = 0, cpha_b = 0, mon_en = 1, fresh = 0, first_pending = 0;
  logic [31:0] slv_word = '0, s_sr = '0;
  logic [7:0] mbyte = '0;
  int mbits = 0, edge_cnt = 0, cs_rises = 0, cs_falls = 0;
  int t_fall = 0, t_first = 0, t_last = 0, t_rise = 0;
  byte unsigned exp_q[$];
  wire cs_all = &cs_n_o;
  assign miso_i = s_sr[31];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge cs_all) begin
    s_sr = slv_word; fresh = 1; mbits = 0;
    t_fall = cyc; first_pending = 1; cs_falls++;
  end
  always @(posedge cs_all) begin cs_rises++; t_rise = cyc; end

  // monitor: collects bits on the sampling edges and scores whole bytes
  always @(sck_o) begin
    edge_cnt++; t_last = cyc;
    if (first_pending) begin t_first = cyc; first_pending = 0; end
    if (!cs_all) begin
      if ((sck_o != cpol_b) ^ cpha_b) begin
        mbyte = {mbyte[6:0], mosi_o};
        mbits++;
        if (mbits == 8) begin
          mbits = 0;
          if (mon_en) begin
            if (exp_q.size() == 0) chk(0, "R4 unexpected serial byte", mbyte, 0);
            else begin
              byte unsigned e;
              e = exp_q.pop_front();
              chk(mbyte == e, "R4/R5 serial byte order", mbyte, e);
            end
          end
        end
      end else begin
        if (cpha_b && fresh) fresh = 0;
        else s_sr = s_sr << 1;
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask
  task automatic set_mode(input logic [7:0] m);
    wr(8'h01, m); cpol_b = m[1]; cpha_b = m[0];
  endtask
  task automatic push(input byte unsigned b); exp_q.push_back(b); endtask
  task automatic run(input logic [3:0] b, input logic [3:0] e, input logic [7:0] r);
    wr(8'h05, 8'h00); wr(8'h02, 8'(b)); wr(8'h03, 8'(e));
    edge_cnt = 0; wr(8'h04, r);
  endtask
  task automatic wait_done(input string tag);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done_o) break;
    end
    chk(done_o == 1'b1, tag, done_o, 1);
  endtask
  task automatic expect_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    logic [7:0] d;
    rd(a, d); chk(d == e, tag, d, e);
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(cs_n_o == 2'b11, "R1 selects idle", cs_n_o, 2'b11);
    chk(sck_o == 1'b0, "R1 clock idle", sck_o, 0);
    chk(done_o == 1'b0, "R1 done clear", done_o, 0);
    expect_rd(8'h00, 8'd8, "R1 divider reset");
    expect_rd(8'h80, 8'h00, "R1 receive byte reset");

    // R2 clamp
    wr(8'h00, 8'd3);  expect_rd(8'h00, 8'd8,  "R2 clamp low");
    wr(8'h00, 8'd10); expect_rd(8'h00, 8'd10, "R2 in range");
    wr(8'h00, 8'd8);

    // R9/R13/R4: three narrow entries in one continued frame, mode 0
    set_mode(8'h00);
    wr(8'hC0, 8'h82); wr(8'hC1, 8'h82); wr(8'hC2, 8'h02);
    wr(8'h40, 8'hA5); wr(8'h42, 8'h3C); wr(8'h44, 8'hF0);
    push(8'hA5); push(8'h3C); push(8'hF0);
    slv_word = 32'h965AC300;
    cs_rises = 0; cs_falls = 0;
    run(4'd0, 4'd2, 8'h40);
    wait_done("R3 done after continued frame");
    chk(cs_falls == 1 && cs_rises == 1, "R9 select held across entries", cs_rises, 1);
    chk(t_first - t_fall == 8, "R13 lead half-period", t_first - t_fall, 8);
    chk(t_rise - t_last == 8, "R13 lag half-period", t_rise - t_last, 8);
    chk(edge_cnt == 48, "R2 edge count narrow x3", edge_cnt, 48);
    expect_rd(8'h80, 8'h96, "R4 rx entry0");
    expect_rd(8'h82, 8'h5A, "R4 rx entry1");
    expect_rd(8'h84, 8'hC3, "R4 rx entry2");
    // R11
    wr(8'h05, 8'h00);
    chk(done_o == 1'b0, "R11 done cleared", done_o, 0);

    // R5/R7/R8/R9: two wide entries, mode 3, device 1, released between
    set_mode(8'h03);
    @(negedge clk);
    chk(sck_o == 1'b1, "R7 idle level high", sck_o, 1);
    wr(8'hC4, 8'h43); wr(8'hC5, 8'h43);
    wr(8'h48, 8'h12); wr(8'h49, 8'h34); wr(8'h4A, 8'hAB); wr(8'h4B, 8'hCD);
    push(8'h12); push(8'h34); push(8'hAB); push(8'hCD);
    slv_word = 32'hE17B0000;
    cs_rises = 0; cs_falls = 0;
    run(4'd4, 4'd5, 8'h40);
    wait_done("R3 done wide");
    chk(cs_rises == 2, "R9 release between entries", cs_rises, 2);
    chk(cs_n_o == 2'b11, "R8 device1 released", cs_n_o, 2'b11);
    expect_rd(8'h88, 8'hE1, "R5 rx first byte e4");
    expect_rd(8'h89, 8'h7B, "R5 rx second byte e4");
    expect_rd(8'h8A, 8'hE1, "R5 rx first byte e5");
    expect_rd(8'h8B, 8'h7B, "R5 rx second byte e5");
    chk(sck_o == 1'b1, "R7 idle after run", sck_o, 1);

    // R6: force 8-bit, mode 1
    set_mode(8'h21);
    wr(8'hC6, 8'h42); wr(8'h4C, 8'h5E); wr(8'h4D, 8'h77);
    push(8'h5E);
    slv_word = 32'h3B000000;
    run(4'd6, 4'd6, 8'h40);
    wait_done("R3 done forced narrow");
    chk(edge_cnt == 16, "R6 only 8 bits shifted", edge_cnt, 16);
    expect_rd(8'h8C, 8'h3B, "R6/R7 rx phase 1");
    expect_rd(8'h8D, 8'h00, "R6 second rx byte untouched");

    // R8: code 0 asserts no select
    set_mode(8'h00);
    wr(8'hC7, 8'h00); wr(8'h4E, 8'hFF);
    cs_falls = 0;
    run(4'd7, 4'd7, 8'h40);
    wait_done("R3 done no select");
    chk(cs_falls == 0, "R8 code 0 selects none", cs_falls, 0);
    chk(edge_cnt == 16, "R8 clock still runs", edge_cnt, 16);

    // R10: hold select after final entry, then R12 release by write 0
    wr(8'hC8, 8'h02); wr(8'h50, 8'h81); push(8'h81);
    slv_word = 32'h55000000;
    run(4'd8, 4'd8, 8'hC0);
    wait_done("R3 done held");
    @(negedge clk);
    chk(cs_n_o == 2'b10, "R10 select kept after final", cs_n_o, 2'b10);
    expect_rd(8'h90, 8'h55, "R4 rx held entry");
    wr(8'h04, 8'h00);
    chk(cs_n_o == 2'b11, "R12 idle write releases", cs_n_o, 2'b11);

    // R3 wrap 15 -> 0 -> 1
    wr(8'hCF, 8'h82); wr(8'hC0, 8'h82); wr(8'hC1, 8'h02);
    wr(8'h5E, 8'h11); wr(8'h40, 8'h22); wr(8'h42, 8'h33);
    push(8'h11); push(8'h22); push(8'h33);
    slv_word = 32'hC1D2E300;
    run(4'd15, 4'd1, 8'h40);
    wait_done("R3 done wrap");
    expect_rd(8'h9E, 8'hC1, "R3 rx entry15");
    expect_rd(8'h80, 8'hD2, "R3 rx entry0 after wrap");
    expect_rd(8'h82, 8'hE3, "R3 rx entry1 after wrap");
    chk(exp_q.size() == 0, "R4 all serial bytes seen", exp_q.size(), 0);

    // R12 abort mid-queue
    for (int i = 0; i < 16; i++) wr(8'(8'hC0 + i), 8'hC2);
    mon_en = 0;
    run(4'd0, 4'd15, 8'h40);
    repeat (100) @(negedge clk);
    wr(8'h04, 8'h00);
    chk(cs_n_o == 2'b11, "R12 abort releases select", cs_n_o, 2'b11);
    chk(sck_o == 1'b0, "R12 abort idles clock", sck_o, 0);
    repeat (3000) @(negedge clk);
    chk(done_o == 1'b0, "R12 abort leaves done clear", done_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule